// File: doc/BRIEF.md
# RAM Section Power Controller

This block holds the power and retention settings for a set of RAM blocks, each split into four sections, and drives the matching per-section power and retention lines to the RAM macros. Software reaches each block through a group of three word addresses: one that reads and writes the settings directly, one where every 1 written turns a bit on, and one where every 1 written turns a bit off. Both alias addresses read back the same settings as the direct address.

A mode input selects normal operation or a deep-sleep state. While asleep every section is unpowered, whatever its power bit says, and the retention lines tell the macros which sections must keep their contents. A section becomes usable a fixed number of clock cycles after its power line rises. The block tracks that delay per section and raises a ready flag when it has passed. Ready drops in the same cycle that the power line falls.

Top module: `ram_pwr_ctrl`

## Requirements
- R1: After reset every settings word reads 0x0000FFFF. All `sect_pwr` lines are 1, all `sect_ret` lines are 0 and all `sect_ready` lines are 0.
- R2: The group for block n sits at byte address 0x600 + 16·n. Offset +0 is the direct word, +4 is the set alias and +8 is the clear alias. A read accepted on one clock edge presents `bus_rvalid` high with its data after that edge, for exactly one cycle.
- R3: A direct write loads bits 3:0 as the power enables of sections 3..0 and bits 19:16 as their retention enables. A value of 1 means on.
- R4: A write to the set alias turns on every enable written as 1 and leaves the enables written as 0 unchanged.
- R5: A write to the clear alias turns off every enable written as 1 and leaves the enables written as 0 unchanged.
- R6: Reading the set alias or the clear alias returns the same word as the direct address.
- R7: Writes to bits outside 3:0 and 19:16 are ignored. Those bits read as 1 for bits 15:4 and as 0 for bits 31:20.
- R8: A read of any address other than the 24 mapped words returns 0. A write to such an address changes nothing.
- R9: With `sys_off` low, line `sect_pwr[4·n+s]` equals the power enable of section s in block n, independently of all other sections.
- R10: With `sys_off` high, every `sect_pwr` line is 0. `sect_ret` still follows the retention enables, and the stored settings are kept.
- R11: `sect_ready` for a section is 0 in every cycle its power line is 0. It rises exactly WAKE_CYCLES clock edges after the power line rises.
- R12: Leaving the sleep state restarts the full WAKE_CYCLES delay for every powered section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sys_off | input | 1 | 1 selects the deep-sleep state |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data returned this cycle |
| sect_pwr | output | NUM_BLOCKS·4 | Per-section power enable to the macros |
| sect_ret | output | NUM_BLOCKS·4 | Per-section retention enable to the macros |
| sect_ready | output | NUM_BLOCKS·4 | Section powered and wake delay elapsed |

## Verification
The bench builds the block with its defaults: eight blocks, a 12-bit address and a wake delay of 10 cycles. With eight blocks the last group (0x670 to 0x678) is mapped, and the word just past it (0x680) lies outside the map, so both sides of the range edge can be reached. A 10-cycle delay is short enough to count edge by edge around the ready rise, both after a single section is turned on and after the block leaves the sleep state.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

    localparam int SECTS    = 4;
    localparam int PWR_LSB  = 0;
    localparam int RET_LSB  = 16;
    localparam int WORD_W   = 32;

    typedef enum logic [1:0] {
        ACC_DIRECT = 2'd0,
        ACC_SET    = 2'd1,
        ACC_CLR    = 2'd2
    } acc_kind_e;

    function automatic logic [SECTS-1:0] take_field(input logic [WORD_W-1:0] word,
                                                    input int lsb);
        return word[lsb +: SECTS];
    endfunction

    // Read image: enables in place, filler ones between the fields, zeros above.
    function automatic logic [WORD_W-1:0] pack_word(input logic [SECTS-1:0] pwr,
                                                    input logic [SECTS-1:0] ret);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = PWR_LSB + SECTS; i < RET_LSB; i++) begin
            w[i] = 1'b1;
        end
        w[PWR_LSB +: SECTS] = pwr;
        w[RET_LSB +: SECTS] = ret;
        return w;
    endfunction

endpackage

// File: rtl/ramp_decode.sv
module ramp_decode #(
    parameter int ADDR_W     = 12,
    parameter int NUM_BLOCKS = 8,
    parameter int BASE_ADDR  = 'h600,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int GRP_W     = ADDR_W - 4
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic                  hit,
    output logic [BLK_W-1:0]      blk,
    output ramp_pkg::acc_kind_e   kind
);
    localparam logic [GRP_W-1:0] GRP_LO = GRP_W'(BASE_ADDR >> 4);
    localparam logic [GRP_W-1:0] GRP_HI = GRP_LO + GRP_W'(NUM_BLOCKS);

    logic [GRP_W-1:0] grp;
    logic [GRP_W-1:0] rel;
    logic             grp_ok;

    always_comb begin
        grp    = addr[ADDR_W-1:4];
        rel    = grp - GRP_LO;
        grp_ok = (grp >= GRP_LO) && (grp < GRP_HI);
        blk    = rel[BLK_W-1:0];
        kind   = ramp_pkg::ACC_DIRECT;
        hit    = 1'b0;
        case (addr[3:0])
            4'h0: begin kind = ramp_pkg::ACC_DIRECT; hit = grp_ok; end
            4'h4: begin kind = ramp_pkg::ACC_SET;    hit = grp_ok; end
            4'h8: begin kind = ramp_pkg::ACC_CLR;    hit = grp_ok; end
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ramp_wake_timer.sv
module ramp_wake_timer #(
    parameter int WAKE_CYCLES = 10,
    localparam int CNT_W      = $clog2(WAKE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on,
    output logic ready
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rdy;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!on) begin
            st_d.cnt = '0;
            st_d.rdy = 1'b0;
        end else if (!st_q.rdy) begin
            if (st_q.cnt == CNT_W'(WAKE_CYCLES - 1)) begin
                st_d.rdy = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Gate with power so ready falls in the same cycle as power.
    assign ready = st_q.rdy & on;
endmodule

// File: rtl/ram_pwr_ctrl.sv
module ram_pwr_ctrl #(
    parameter int NUM_BLOCKS  = 8,
    parameter int ADDR_W      = 12,
    parameter int WAKE_CYCLES = 10,
    localparam int NS         = ramp_pkg::SECTS,
    localparam int NSEC       = NUM_BLOCKS * NS,
    localparam int BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_off,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic [NSEC-1:0]   sect_pwr,
    output logic [NSEC-1:0]   sect_ret,
    output logic [NSEC-1:0]   sect_ready
);
    import ramp_pkg::*;

    typedef struct packed {
        logic [NUM_BLOCKS-1:0][NS-1:0] pwr;
        logic [NUM_BLOCKS-1:0][NS-1:0] ret;
        logic [31:0]                   rdata;
        logic                          rvalid;
    } ctl_t;

    ctl_t st_d, st_q;

    logic             hit;
    logic [BLK_W-1:0] blk;
    acc_kind_e        kind;
    logic [NS-1:0]    w_pwr;
    logic [NS-1:0]    w_ret;

    ramp_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_BLOCKS (NUM_BLOCKS)
    ) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .blk  (blk),
        .kind (kind)
    );

    always_comb begin
        w_pwr       = take_field(bus_wdata, PWR_LSB);
        w_ret       = take_field(bus_wdata, RET_LSB);
        st_d        = st_q;
        st_d.rvalid = bus_valid & ~bus_write;
        st_d.rdata  = '0;
        if (bus_valid && hit) begin
            if (bus_write) begin
                case (kind)
                    ACC_SET: begin
                        st_d.pwr[blk] = st_q.pwr[blk] | w_pwr;
                        st_d.ret[blk] = st_q.ret[blk] | w_ret;
                    end
                    ACC_CLR: begin
                        st_d.pwr[blk] = st_q.pwr[blk] & ~w_pwr;
                        st_d.ret[blk] = st_q.ret[blk] & ~w_ret;
                    end
                    default: begin
                        st_d.pwr[blk] = w_pwr;
                        st_d.ret[blk] = w_ret;
                    end
                endcase
            end else begin
                st_d.rdata = pack_word(st_q.pwr[blk], st_q.ret[blk]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.pwr    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;
    assign sect_pwr   = st_q.pwr & {NSEC{~sys_off}};
    assign sect_ret   = st_q.ret;

    for (genvar i = 0; i < NSEC; i++) begin : g_sect
        ramp_wake_timer #(
            .WAKE_CYCLES (WAKE_CYCLES)
        ) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .on    (sect_pwr[i]),
            .ready (sect_ready[i])
        );
    end
endmodule

// File: rtl/ram_pwr_ctrl_chk.sv
module ram_pwr_ctrl_chk #(
    parameter int NSEC = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sys_off,
    input logic            bus_valid,
    input logic            bus_write,
    input logic            bus_rvalid,
    input logic [NSEC-1:0] sect_pwr,
    input logic [NSEC-1:0] sect_ret,
    input logic [NSEC-1:0] sect_ready
);
    assert_sleep_unpowered_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_off |-> (sect_pwr == '0));

    assert_ret_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> $stable(sect_ret));

    assert_ready_needs_power_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sect_ready & ~sect_pwr) == '0);

    assert_ready_rise_after_power_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sect_ready & ~$past(sect_ready) & ~$past(sect_pwr)) == '0);

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    assert_no_stray_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !bus_rvalid);
endmodule

bind ram_pwr_ctrl ram_pwr_ctrl_chk #(
    .NSEC (NSEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_off    (sys_off),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_rvalid (bus_rvalid),
    .sect_pwr   (sect_pwr),
    .sect_ret   (sect_ret),
    .sect_ready (sect_ready)
);

// File: tb/ram_pwr_ctrl_test.sv
`timescale 1ns/1ps
module ram_pwr_ctrl_test;
    localparam int NB   = 8;
    localparam int AW   = 12;
    localparam int WAKE = 10;
    localparam int NSEC = NB * 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sys_off = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            bus_rvalid;
    logic [NSEC-1:0] sect_pwr, sect_ret, sect_ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [3:0] mp [NB];
    logic [3:0] mr [NB];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    ram_pwr_ctrl #(.NUM_BLOCKS(NB), .ADDR_W(AW), .WAKE_CYCLES(WAKE)) uut (
        .clk(clk), .rst_n(rst_n), .sys_off(sys_off),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .sect_pwr(sect_pwr), .sect_ret(sect_ret), .sect_ready(sect_ready)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int b);
        return {12'h000, mr[b], 12'hFFF, mp[b]};
    endfunction

    function automatic logic [NSEC-1:0] pwr_vec();
        logic [NSEC-1:0] v;
        for (int b = 0; b < NB; b++) v[b*4 +: 4] = mp[b];
        return v;
    endfunction

    function automatic logic [NSEC-1:0] ret_vec();
        logic [NSEC-1:0] v;
        for (int b = 0; b < NB; b++) v[b*4 +: 4] = mr[b];
        return v;
    endfunction

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // Monitor: pops the expected word when read data comes back.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected rvalid", 64'(bus_rvalid), 64'(0));
            end else begin
                check(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) begin mp[b] = 4'hF; mr[b] = 4'h0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 sect_pwr after reset", 64'(sect_pwr), 64'(pwr_vec()));
        check("R1 sect_ret after reset", 64'(sect_ret), 64'(0));
        check("R1 sect_ready after reset", 64'(sect_ready), 64'(0));
        for (int b = 0; b < NB; b++)
            bus_rd(AW'(12'h600 + 16*b), 32'h0000FFFF, "R1 R2 reset word");
        bus_rd(12'h604, 32'h0000FFFF, "R6 set alias read at reset");
        bus_rd(12'h608, 32'h0000FFFF, "R6 clear alias read at reset");
        repeat (4) @(negedge clk);
        check("R11 all ready after delay", 64'(sect_ready), 64'(pwr_vec()));
        check("R2 no rvalid when idle", 64'(bus_rvalid), 64'(0));

        // R3 direct write
        bus_wr(12'h630, 32'h000A0005); mp[3] = 4'h5; mr[3] = 4'hA;
        check("R3 R9 sect_pwr after direct write", 64'(sect_pwr), 64'(pwr_vec()));
        check("R3 sect_ret after direct write", 64'(sect_ret), 64'(ret_vec()));
        bus_rd(12'h630, word_of(3), "R3 direct readback");
        // R7 undefined bits ignored
        bus_wr(12'h630, 32'hFFF0FFF3); mp[3] = 4'h3; mr[3] = 4'h0;
        bus_rd(12'h630, 32'h0000FFF3, "R7 filler bits on read");

        // R4 / R5 aliases on block 5
        bus_wr(12'h654, 32'h00030002); mr[5] = 4'h3;
        bus_rd(12'h650, 32'h0003FFFF, "R4 set alias");
        bus_wr(12'h658, 32'h00010005); mp[5] = 4'hA; mr[5] = 4'h2;
        bus_rd(12'h654, 32'h0002FFFA, "R5 R6 set alias read after clear");
        bus_rd(12'h658, 32'h0002FFFA, "R6 clear alias read");
        check("R9 sect_pwr block 5", 64'(sect_pwr), 64'(pwr_vec()));

        // Last block
        bus_wr(12'h678, 32'h0000000F); mp[7] = 4'h0;
        bus_wr(12'h674, 32'h00080009); mp[7] = 4'h9; mr[7] = 4'h8;
        bus_rd(12'h670, word_of(7), "R2 R4 R5 last group");

        // R8 unmapped accesses
        bus_wr(12'h680, 32'h00000000);
        bus_wr(12'h60C, 32'h00000000);
        bus_wr(12'h5F0, 32'h00000000);
        bus_wr(12'h602, 32'h00000000);
        bus_rd(12'h680, 32'h0, "R8 read past last group");
        bus_rd(12'h60C, 32'h0, "R8 read unmapped offset");
        bus_rd(12'h5F0, 32'h0, "R8 read below map");
        bus_rd(12'h600, word_of(0), "R8 block 0 unchanged");
        check("R8 sect_pwr unchanged", 64'(sect_pwr), 64'(pwr_vec()));
        check("R8 sect_ret unchanged", 64'(sect_ret), 64'(ret_vec()));

        // R11 ready timing on block 3 section 0 (line 12)
        bus_wr(12'h638, 32'h00000001); mp[3] = 4'h2;
        check("R11 power off line 12", 64'(sect_pwr[12]), 64'(0));
        check("R11 ready drops with power", 64'(sect_ready[12]), 64'(0));
        check("R9 neighbour section unaffected", 64'(sect_ready[13]), 64'(1));
        bus_wr(12'h634, 32'h00000001); mp[3] = 4'h3;
        check("R11 power on line 12", 64'(sect_pwr[12]), 64'(1));
        check("R11 ready low at power on", 64'(sect_ready[12]), 64'(0));
        repeat (WAKE - 1) @(negedge clk);
        check("R11 ready low one edge early", 64'(sect_ready[12]), 64'(0));
        @(negedge clk);
        check("R11 ready high at delay", 64'(sect_ready[12]), 64'(1));

        // R10 sleep state
        @(negedge clk);
        sys_off = 1'b1;
        #1;
        check("R10 all power off in sleep", 64'(sect_pwr), 64'(0));
        check("R10 ready off in sleep", 64'(sect_ready), 64'(0));
        check("R10 retention kept in sleep", 64'(sect_ret), 64'(ret_vec()));
        bus_rd(12'h650, word_of(5), "R10 settings kept in sleep");
        bus_wr(12'h614, 32'h00040000); mr[1] = 4'h4;
        check("R10 retention write in sleep", 64'(sect_ret), 64'(ret_vec()));
        check("R10 power still off", 64'(sect_pwr), 64'(0));
        @(negedge clk);
        sys_off = 1'b0;
        #1;
        check("R9 R12 power restored", 64'(sect_pwr), 64'(pwr_vec()));
        check("R12 ready low on wake", 64'(sect_ready), 64'(0));
        @(negedge clk);
        repeat (WAKE - 2) @(negedge clk);
        check("R12 ready low one edge early", 64'(sect_ready), 64'(0));
        @(negedge clk);
        check("R12 ready after full delay", 64'(sect_ready), 64'(pwr_vec()));

        repeat (3) @(negedge clk);
        check("R2 all reads returned", 64'(exp_q.size()), 64'(0));
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule